// File: doc/BRIEF.md
# PCI Target Read Window Controller

This block takes a PCI target read that has already been decoded to one of four windows and turns it into a read on an internal system bus. Windows 0 to 2 map memory space. Window 3 maps I/O space. Three enables must all agree before a window claims an access: a global target-access enable, a memory-space or I/O-space enable, and the window's own enable. The memory-space and I/O-space enables come from host-side status inputs in host mode and from command-register inputs in satellite mode.

Each memory window has a prefetch control. When it is on, a read is issued on the internal bus as a burst whose length comes from that window's burst-length field. When it is off, and always for the I/O window, exactly one word is read. A PCI burst read that the window cannot prefetch is served as one word, and that word is then flagged for disconnect. Returned words pass through a per-window byte-reversal stage into an in-order buffer. The PCI side then drains them under its own flow control.

Top module: `pcitgt_window_ctl`

## Requirements
- R1: A request to memory window 0, 1 or 2 is claimed only when `tgt_access_en`, the selected memory-space enable and `win_enable[w]` are all 1.
- R2: A request to window 3 (I/O) is claimed only when `tgt_access_en`, the selected I/O-space enable and `win_enable[3]` are all 1.
- R3: With `host_mode` = 1 the space enables are taken from `host_mem_space` and `host_io_space`. With `host_mode` = 0 they are taken from `cmd_mem_space` and `cmd_io_space`.
- R4: After reset, prefetch is on for windows 0 and 1 and off for window 2. A cycle with `pf_wr_en` = 1 loads `pf_wr_data`, where bit w controls memory window w.
- R5: Window 3 never prefetches. Each read to it, burst or not, moves exactly one word.
- R6: A claimed read to a prefetching memory window issues one internal request with `ib_req_len` = `burst_len_cfg[3w+2:3w]`. The request moves that value plus one words.
- R7: A claimed read to a window without prefetch issues one internal request with `ib_req_len` = 0 and delivers one word.
- R8: A burst read (`req_burst` = 1) to a window without prefetch delivers one word, and `pd_disconnect` = 1 with that word. `pd_disconnect` stays 0 otherwise.
- R9: An unclaimed request gives a one-cycle `tgt_unclaimed` pulse in the cycle after acceptance. It starts no internal request and delivers no data.
- R10: When `win_swap[w]` = 1, each word from window w is delivered byte-reversed: byte 0 is swapped with byte 3, and byte 1 with byte 2. Otherwise it is delivered unchanged.
- R11: Words reach `pd_data` in the order the internal bus returned them, with none lost under `pd_ready` backpressure. `pd_last` = 1 only on the final word.
- R12: `tgt_claim` pulses in the cycle after acceptance, together with `ib_req_valid`. `ib_req_addr` equals `req_addr`, and the request is held stable until `ib_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_access_en | input | 1 | Global target access enable |
| host_mode | input | 1 | 1 selects host-side space enables |
| host_mem_space | input | 1 | Memory-space enable, host mode |
| host_io_space | input | 1 | I/O-space enable, host mode |
| cmd_mem_space | input | 1 | Memory-space enable, satellite mode |
| cmd_io_space | input | 1 | I/O-space enable, satellite mode |
| win_enable | input | 4 | Per-window enable, bit 3 is I/O |
| win_swap | input | 4 | Per-window byte reversal |
| burst_len_cfg | input | 9 | Three 3-bit burst-length fields, window 0 in the low bits |
| pf_wr_en | input | 1 | Load prefetch controls |
| pf_wr_data | input | 3 | New prefetch controls, bit w for memory window w |
| req_valid | input | 1 | Decoded target read present |
| req_ready | output | 1 | Controller idle and accepting |
| req_win | input | 2 | Target window index |
| req_addr | input | 32 | Target address |
| req_burst | input | 1 | PCI side requests a burst |
| tgt_claim | output | 1 | Request claimed (pulse) |
| tgt_unclaimed | output | 1 | Request not claimed (pulse) |
| ib_req_valid | output | 1 | Internal read request valid |
| ib_req_ready | input | 1 | Internal bus accepts request |
| ib_req_addr | output | 32 | Internal read start address |
| ib_req_len | output | 3 | Words minus one |
| ib_rd_valid | input | 1 | Read word valid |
| ib_rd_ready | output | 1 | Controller can take a read word |
| ib_rd_data | input | 32 | Read word |
| pd_valid | output | 1 | Word available to PCI side |
| pd_ready | input | 1 | PCI side takes the word |
| pd_data | output | 32 | Word after optional byte reversal |
| pd_last | output | 1 | Final word of this read |
| pd_disconnect | output | 1 | Disconnect after this word |

## Verification
The hardest state to reach is a full return buffer. The internal bus must still hold words to deliver while the PCI side keeps refusing them. Only then does `ib_rd_ready` drop, and only then can a lost or reordered word show up. The bench reaches this state with the longest burst length, a delayed request acceptance and a periodic stall of `pd_ready`. With those settings an eight-word burst outruns the four-entry buffer. The bench then checks every word against a pattern made from the address and the beat index.

// File: rtl/pcitgt_pkg.sv
package pcitgt_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_XFER  = 2'd2
    } xfer_st_e;
endpackage

// File: rtl/pcitgt_win_gate.sv
// Claim and prefetch decision for one window.
module pcitgt_win_gate #(
    parameter bit PF_CAPABLE = 1'b1
) (
    input  logic global_en,
    input  logic space_en,
    input  logic own_en,
    input  logic pf_cfg,
    output logic usable,
    output logic pf_allowed
);
    assign usable     = global_en & space_en & own_en;
    assign pf_allowed = PF_CAPABLE & pf_cfg;
endmodule

// File: rtl/pcitgt_lane_swap.sv
// Optional reversal of the bytes of one data word.
module pcitgt_lane_swap #(
    parameter int DW = 32
) (
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;
    logic [DW-1:0] rev;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/pcitgt_rdbuf.sv
// In-order return buffer, power-of-two depth.
module pcitgt_rdbuf #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW:0] wp;
        logic [PW:0] rp;
    } ptr_t;

    ptr_t         p_d, p_q;
    logic [W-1:0] store_q [DEPTH];

    always_comb begin
        p_d = p_q;
        if (push) p_d.wp = p_q.wp + (PW+1)'(1);
        if (pop)  p_d.rp = p_q.rp + (PW+1)'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push) store_q[p_q.wp[PW-1:0]] <= push_data;
    end

    assign empty = (p_q.wp == p_q.rp);
    assign full  = (p_q.wp[PW] != p_q.rp[PW]) && (p_q.wp[PW-1:0] == p_q.rp[PW-1:0]);
    assign head  = store_q[p_q.rp[PW-1:0]];
endmodule

// File: rtl/pcitgt_window_ctl.sv
module pcitgt_window_ctl
    import pcitgt_pkg::*;
#(
    parameter int              NMEM      = 3,
    parameter int              AW        = 32,
    parameter int              DW        = 32,
    parameter int              BLW       = 3,
    parameter int              BUF_DEPTH = 4,
    parameter logic [NMEM-1:0] PF_RESET  = 3'b011,
    localparam int             NWIN      = NMEM + 1,
    localparam int             WIW       = $clog2(NWIN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tgt_access_en,
    input  logic                host_mode,
    input  logic                host_mem_space,
    input  logic                host_io_space,
    input  logic                cmd_mem_space,
    input  logic                cmd_io_space,
    input  logic [NWIN-1:0]     win_enable,
    input  logic [NWIN-1:0]     win_swap,
    input  logic [NMEM*BLW-1:0] burst_len_cfg,
    input  logic                pf_wr_en,
    input  logic [NMEM-1:0]     pf_wr_data,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [WIW-1:0]      req_win,
    input  logic [AW-1:0]       req_addr,
    input  logic                req_burst,
    output logic                tgt_claim,
    output logic                tgt_unclaimed,
    output logic                ib_req_valid,
    input  logic                ib_req_ready,
    output logic [AW-1:0]       ib_req_addr,
    output logic [BLW-1:0]      ib_req_len,
    input  logic                ib_rd_valid,
    output logic                ib_rd_ready,
    input  logic [DW-1:0]       ib_rd_data,
    output logic                pd_valid,
    input  logic                pd_ready,
    output logic [DW-1:0]       pd_data,
    output logic                pd_last,
    output logic                pd_disconnect
);
    localparam int CNTW = BLW + 1;

    typedef struct packed {
        xfer_st_e        st;
        logic [NMEM-1:0] pf;
        logic [AW-1:0]   addr;
        logic [BLW-1:0]  len;
        logic [CNTW-1:0] rx_left;
        logic [CNTW-1:0] tx_left;
        logic            swap;
        logic            disc;
        logic            claim;
        logic            unclaim;
    } ctl_t;

    ctl_t r_d, r_q;

    // Space enables, chosen by operating mode
    logic mem_space, io_space;
    assign mem_space = host_mode ? host_mem_space : cmd_mem_space;
    assign io_space  = host_mode ? host_io_space  : cmd_io_space;

    logic [NWIN-1:0] win_ok, win_pf;
    logic [BLW-1:0]  win_blen [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        if (w < NMEM) begin : g_mem
            pcitgt_win_gate #(.PF_CAPABLE(1'b1)) i_gate (
                .global_en (tgt_access_en),
                .space_en  (mem_space),
                .own_en    (win_enable[w]),
                .pf_cfg    (r_q.pf[w]),
                .usable    (win_ok[w]),
                .pf_allowed(win_pf[w])
            );
            assign win_blen[w] = burst_len_cfg[w*BLW +: BLW];
        end else begin : g_io
            pcitgt_win_gate #(.PF_CAPABLE(1'b0)) i_gate (
                .global_en (tgt_access_en),
                .space_en  (io_space),
                .own_en    (win_enable[w]),
                .pf_cfg    (1'b0),
                .usable    (win_ok[w]),
                .pf_allowed(win_pf[w])
            );
            assign win_blen[w] = '0;
        end
    end

    // Return path
    logic          buf_full, buf_empty, rx_fire, tx_fire;
    logic [DW-1:0] swapped, buf_head;

    assign rx_fire = ib_rd_valid & ib_rd_ready;
    assign tx_fire = pd_valid & pd_ready;

    pcitgt_lane_swap #(.DW(DW)) i_swap (
        .en  (r_q.swap),
        .din (ib_rd_data),
        .dout(swapped)
    );

    pcitgt_rdbuf #(.W(DW), .DEPTH(BUF_DEPTH)) i_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_fire),
        .push_data(swapped),
        .pop      (tx_fire),
        .full     (buf_full),
        .empty    (buf_empty),
        .head     (buf_head)
    );

    logic [BLW-1:0] sel_len;

    always_comb begin
        r_d         = r_q;
        r_d.claim   = 1'b0;
        r_d.unclaim = 1'b0;
        sel_len     = '0;
        if (pf_wr_en) r_d.pf = pf_wr_data;

        unique case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if (win_ok[req_win]) begin
                        sel_len     = win_pf[req_win] ? win_blen[req_win] : '0;
                        r_d.claim   = 1'b1;
                        r_d.st      = S_ISSUE;
                        r_d.addr    = req_addr;
                        r_d.len     = sel_len;
                        r_d.swap    = win_swap[req_win];
                        r_d.disc    = req_burst & ~win_pf[req_win];
                        r_d.rx_left = {1'b0, sel_len} + CNTW'(1);
                        r_d.tx_left = {1'b0, sel_len} + CNTW'(1);
                    end else begin
                        r_d.unclaim = 1'b1;
                    end
                end
            end
            S_ISSUE: begin
                if (ib_req_ready) r_d.st = S_XFER;
            end
            S_XFER: begin
                if (rx_fire) r_d.rx_left = r_q.rx_left - CNTW'(1);
                if (tx_fire) begin
                    r_d.tx_left = r_q.tx_left - CNTW'(1);
                    if (r_q.tx_left == CNTW'(1)) r_d.st = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.pf <= PF_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == S_IDLE);
    assign tgt_claim     = r_q.claim;
    assign tgt_unclaimed = r_q.unclaim;
    assign ib_req_valid  = (r_q.st == S_ISSUE);
    assign ib_req_addr   = r_q.addr;
    assign ib_req_len    = r_q.len;
    assign ib_rd_ready   = (r_q.st == S_XFER) && (r_q.rx_left != '0) && !buf_full;
    assign pd_valid      = !buf_empty;
    assign pd_data       = buf_head;
    assign pd_last       = pd_valid && (r_q.tx_left == CNTW'(1));
    assign pd_disconnect = pd_last && r_q.disc;
endmodule

// File: rtl/pcitgt_window_ctl_chk.sv
module pcitgt_window_ctl_chk #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int BLW    = 3,
    parameter int WIW    = 2,
    parameter int IO_IDX = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic [WIW-1:0] req_win,
    input logic           tgt_claim,
    input logic           tgt_unclaimed,
    input logic           ib_req_valid,
    input logic           ib_req_ready,
    input logic [AW-1:0]  ib_req_addr,
    input logic [BLW-1:0] ib_req_len,
    input logic           pd_valid,
    input logic           pd_ready,
    input logic [DW-1:0]  pd_data,
    input logic           pd_last,
    input logic           pd_disconnect
);
    p_claim_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tgt_claim, tgt_unclaimed}));

    p_unclaimed_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_unclaimed |-> !ib_req_valid);

    p_claim_issues_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_claim |-> ib_req_valid);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req_valid && !ib_req_ready |=> ib_req_valid && $stable(ib_req_addr) && $stable(ib_req_len));

    p_io_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_win == WIW'(IO_IDX)) |=> !ib_req_valid || (ib_req_len == '0));

    p_disc_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_disconnect |-> pd_valid && pd_last);

    p_pd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pd_valid && !pd_ready |=> pd_valid && $stable(pd_data));

    p_last_drains_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pd_valid && pd_ready && pd_last |=> !pd_valid);
endmodule

bind pcitgt_window_ctl pcitgt_window_ctl_chk #(
    .AW(AW), .DW(DW), .BLW(BLW), .WIW(WIW), .IO_IDX(NMEM)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_win(req_win), .tgt_claim(tgt_claim), .tgt_unclaimed(tgt_unclaimed),
    .ib_req_valid(ib_req_valid), .ib_req_ready(ib_req_ready),
    .ib_req_addr(ib_req_addr), .ib_req_len(ib_req_len),
    .pd_valid(pd_valid), .pd_ready(pd_ready), .pd_data(pd_data),
    .pd_last(pd_last), .pd_disconnect(pd_disconnect)
);

// File: tb/test_pcitgt_window_ctl.sv
`timescale 1ns/1ps
module test_pcitgt_window_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tgt_access_en, host_mode, host_mem_space, host_io_space;
    logic        cmd_mem_space, cmd_io_space;
    logic [3:0]  win_enable, win_swap;
    logic [8:0]  burst_len_cfg;
    logic        pf_wr_en;
    logic [2:0]  pf_wr_data;
    logic        req_valid, req_ready, req_burst;
    logic [1:0]  req_win;
    logic [31:0] req_addr;
    logic        tgt_claim, tgt_unclaimed;
    logic        ib_req_valid, ib_req_ready;
    logic [31:0] ib_req_addr;
    logic [2:0]  ib_req_len;
    logic        ib_rd_valid, ib_rd_ready;
    logic [31:0] ib_rd_data;
    logic        pd_valid, pd_ready, pd_last, pd_disconnect;
    logic [31:0] pd_data;

    always #5 clk = ~clk;

    pcitgt_window_ctl i_pcitgt_window_ctl (.*);

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] beat_word(input logic [31:0] a, input int i);
        return {8'hC0 + 8'(i), 8'h35 ^ a[7:0], 8'h5A + 8'(i), a[7:0] + 8'(i)};
    endfunction

    function automatic logic [31:0] rev32(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    // Internal bus responder
    int          rsp_delay = 0;
    int          n_ib_req  = 0;
    logic [31:0] last_addr;
    logic [2:0]  last_len;
    bit          busy = 0, req_fire_p = 0, rd_fire_p = 0;
    int          beat = 0, wait_cnt = 0;

    always @(negedge clk) begin
        if (rd_fire_p) begin
            beat++;
            if (beat == int'(last_len) + 1) busy = 0;
        end
        rd_fire_p  = 0;
        req_fire_p = 0;
        ib_req_ready = 1'b0;
        if (rst_n && !busy && ib_req_valid) begin
            if (wait_cnt >= rsp_delay) begin
                ib_req_ready = 1'b1;
                req_fire_p   = 1;
                last_addr    = ib_req_addr;
                last_len     = ib_req_len;
                busy         = 1;
                beat         = 0;
                wait_cnt     = 0;
                n_ib_req++;
            end else begin
                wait_cnt++;
            end
        end
        if (busy && !req_fire_p) begin
            ib_rd_valid = 1'b1;
            ib_rd_data  = beat_word(last_addr, beat);
            rd_fire_p   = ib_rd_ready;
        end else begin
            ib_rd_valid = 1'b0;
            ib_rd_data  = '0;
        end
    end

    // PCI-side sink
    bit          stall = 0;
    int          cyc   = 0;
    int          n_pop = 0;
    logic [31:0] got_d [64];
    bit          got_l [64];
    bit          got_x [64];

    always @(negedge clk) begin
        pd_ready = stall ? (cyc % 3 != 0) : 1'b1;
        cyc++;
        if (rst_n && pd_valid && pd_ready) begin
            got_d[n_pop % 64] = pd_data;
            got_l[n_pop % 64] = pd_last;
            got_x[n_pop % 64] = pd_disconnect;
            n_pop++;
        end
    end

    task automatic do_read(input int win, input logic [31:0] addr, input bit burst,
                           input bit exp_claim, input int exp_beats, input bit exp_disc,
                           input bit exp_swap, input string tag);
        int base_req = n_ib_req;
        int base_pop = n_pop;
        int t = 0;
        @(negedge clk);
        req_valid = 1'b1; req_win = 2'(win); req_addr = addr; req_burst = burst;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_burst = 1'b0;
        chk(tgt_claim == exp_claim, {tag, " claim"}, tgt_claim, exp_claim);
        chk(tgt_unclaimed == !exp_claim, {tag, " unclaimed R9"}, tgt_unclaimed, !exp_claim);
        if (exp_claim) begin
            while (n_pop < base_pop + exp_beats && t < 400) begin
                @(negedge clk); t++;
            end
            chk(last_addr == addr, {tag, " R12 address"}, last_addr, addr);
            chk(int'(last_len) == exp_beats - 1, {tag, " length"}, last_len, exp_beats - 1);
            for (int i = 0; i < exp_beats; i++) begin
                logic [31:0] e = exp_swap ? rev32(beat_word(addr, i)) : beat_word(addr, i);
                int k = (base_pop + i) % 64;
                chk(got_d[k] == e, {tag, " data R11"}, got_d[k], e);
                chk(got_l[k] == (i == exp_beats - 1), {tag, " last R11"}, got_l[k], i == exp_beats - 1);
                chk(got_x[k] == (exp_disc && i == exp_beats - 1), {tag, " disconnect R8"},
                    got_x[k], exp_disc && i == exp_beats - 1);
            end
        end
        repeat (4) @(negedge clk);
        chk(n_ib_req == base_req + (exp_claim ? 1 : 0), {tag, " request count"},
            n_ib_req - base_req, exp_claim ? 1 : 0);
        chk(n_pop == base_pop + exp_beats, {tag, " word count"}, n_pop - base_pop, exp_beats);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R12 reset ready", req_ready, 1);
        chk(ib_req_valid == 1'b0, "R12 reset request", ib_req_valid, 0);
        chk(pd_valid == 1'b0, "R11 reset data", pd_valid, 0);
        chk(tgt_claim == 1'b0 && tgt_unclaimed == 1'b0, "R9 reset pulses", {tgt_claim, tgt_unclaimed}, 0);
    endtask

    task automatic t_defaults();
        do_read(0, 32'h0000_1000, 0, 1, 3, 0, 0, "R6 w0 prefetch");
        do_read(1, 32'h0000_2040, 0, 1, 6, 0, 0, "R4 w1 prefetch default");
        do_read(2, 32'h0000_3080, 0, 1, 1, 0, 0, "R7 w2 single");
        do_read(3, 32'h0000_00C4, 0, 1, 1, 0, 0, "R7 io single");
    endtask

    task automatic t_burst_refuse();
        do_read(2, 32'h0000_3100, 1, 1, 1, 1, 0, "R8 w2 burst");
        do_read(3, 32'h0000_00D0, 1, 1, 1, 1, 0, "R5 io burst");
        do_read(0, 32'h0000_1200, 1, 1, 3, 0, 0, "R6 w0 burst");
    endtask

    task automatic t_pf_write();
        @(negedge clk); pf_wr_en = 1'b1; pf_wr_data = 3'b100;
        @(negedge clk); pf_wr_en = 1'b0;
        do_read(2, 32'h0000_3300, 0, 1, 4, 0, 0, "R4 w2 prefetch written");
        do_read(0, 32'h0000_1300, 1, 1, 1, 1, 0, "R4 w0 prefetch cleared");
        @(negedge clk); pf_wr_en = 1'b1; pf_wr_data = 3'b011;
        @(negedge clk); pf_wr_en = 1'b0;
    endtask

    task automatic t_gating();
        tgt_access_en = 1'b0;
        do_read(0, 32'h0000_1400, 0, 0, 0, 0, 0, "R1 global off");
        do_read(3, 32'h0000_00E0, 0, 0, 0, 0, 0, "R2 global off");
        tgt_access_en = 1'b1;
        cmd_mem_space = 1'b0;
        do_read(1, 32'h0000_2400, 0, 0, 0, 0, 0, "R1 memory space off");
        do_read(3, 32'h0000_00E4, 0, 1, 1, 0, 0, "R2 io on memory off");
        cmd_mem_space = 1'b1;
        win_enable = 4'b1011;
        do_read(2, 32'h0000_3400, 0, 0, 0, 0, 0, "R1 window off");
        do_read(0, 32'h0000_1500, 0, 1, 3, 0, 0, "R1 other window on");
        win_enable = 4'b1111;
        cmd_io_space = 1'b0;
        do_read(3, 32'h0000_00E8, 0, 0, 0, 0, 0, "R2 io space off");
        cmd_io_space = 1'b1;
    endtask

    task automatic t_mode();
        host_mode = 1'b1; host_mem_space = 1'b1; host_io_space = 1'b0;
        cmd_mem_space = 1'b0; cmd_io_space = 1'b1;
        do_read(0, 32'h0000_1600, 0, 1, 3, 0, 0, "R3 host memory");
        do_read(3, 32'h0000_00EC, 0, 0, 0, 0, 0, "R3 host io");
        host_mode = 1'b0;
        do_read(0, 32'h0000_1700, 0, 0, 0, 0, 0, "R3 satellite memory");
        cmd_mem_space = 1'b1; host_mem_space = 1'b0;
    endtask

    task automatic t_swap();
        win_swap = 4'b0010;
        do_read(1, 32'h0000_2800, 0, 1, 6, 0, 1, "R10 w1 swapped");
        do_read(0, 32'h0000_1800, 0, 1, 3, 0, 0, "R10 w0 plain");
        win_swap = 4'b1000;
        do_read(3, 32'h0000_00F0, 0, 1, 1, 0, 1, "R10 io swapped");
        win_swap = 4'b0000;
    endtask

    task automatic t_backpressure();
        burst_len_cfg = {3'd3, 3'd5, 3'd7};
        stall = 1; rsp_delay = 3;
        do_read(0, 32'h0000_1900, 1, 1, 8, 0, 0, "R11 backpressure");
        stall = 0; rsp_delay = 0;
        burst_len_cfg = {3'd3, 3'd5, 3'd2};
    endtask

    initial begin : watchdog
        int n = 0;
        while (!done && n < 100000) begin
            @(posedge clk); n++;
        end
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected 0", n);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        tgt_access_en = 1'b1; host_mode = 1'b0; host_mem_space = 1'b0; host_io_space = 1'b0;
        cmd_mem_space = 1'b1; cmd_io_space = 1'b1;
        win_enable = 4'b1111; win_swap = 4'b0000;
        burst_len_cfg = {3'd3, 3'd5, 3'd2};
        pf_wr_en = 1'b0; pf_wr_data = '0;
        req_valid = 1'b0; req_win = '0; req_addr = '0; req_burst = 1'b0;
        ib_req_ready = 1'b0; ib_rd_valid = 1'b0; ib_rd_data = '0; pd_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_burst_refuse();
        t_pf_write();
        t_gating();
        t_mode();
        t_swap();
        t_backpressure();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule